// File: doc/BRIEF.md
# Dual-Pointer Stack Memory Unit

This block is a 128-word by 32-bit local RAM served by two independent 7-bit stack pointers, A and B. Each pointer has its own command lane: a valid strobe, a 4-bit operation code, a 32-bit operand and a small set of flag inputs. A lane can push or pop in either direction, with the address adjusted before or after the access depending on the direction, and can load, read, add to or subtract from its pointer. Both lanes reach the same storage, so two stacks can live side by side; starting both at address 0 and running one upward and one downward makes them grow apart, the downward one wrapping to the top word.

Each lane also offers call and return helpers. A call stores a frame holding a 9-bit return address plus the carry and zero flags, then announces a jump to its target. A return unwinds the frame, announces a jump to the stored address and hands back each flag only if that flag's restore enable was set. All results are registered and appear as one-cycle strobes in the cycle after the command is taken.

When both lanes touch the same word in the same cycle, lane A goes ahead and lane B is held off for that cycle by a ready signal.

Top module: `dual_stack_mem`

## Requirements
- R1: After reset both pointers are 0, every result strobe (read, jump, carry, zero) on both lanes is low, and `b_ready` is high while lane B is idle.
- R2: Op code 0 (push-up) writes the operand at the pointer's current address and then adds 1 to the pointer; op code 2 (pop-down) subtracts 1 from the pointer and then reads the word at the new address, delivering it on the lane's read data with its read strobe in the next cycle.
- R3: Op code 1 (push-down) subtracts 1 from the pointer and then writes the operand at the new address; op code 3 (pop-up) reads the word at the current address and then adds 1 to the pointer, the data appearing with the read strobe in the next cycle.
- R4: Op code 4 (set) loads operand bits [6:0] into the pointer, ignoring higher bits; op code 5 (get) returns the pointer, zero-extended to 32 bits, on the read data with the read strobe in the next cycle.
- R5: Op code 6 (add) and op code 7 (subtract) change the pointer by operand bits [6:0], modulo 128.
- R6: Op code 8 (call) writes a frame at the current address and then adds 1 to the pointer; the frame holds operand bits [24:16] as the return address in bits [8:0], the zero-flag input in bit 9, the carry-flag input in bit 10 and zeros above. In the next cycle the jump strobe is high with jump address equal to operand bits [8:0].
- R7: Op code 9 (return) subtracts 1 from the pointer, reads the frame there and in the next cycle raises the jump strobe with jump address equal to frame bits [8:0]; the carry strobe rises with frame bit 10 only if the carry restore enable was set, and the zero strobe rises with frame bit 9 only if the zero restore enable was set.
- R8: Pointer arithmetic wraps at 7 bits: a push-down from pointer 0 writes address 127, so with both pointers at 0, push-up on A and push-down on B in the same cycle proceed together without stalling.
- R9: When both lanes are valid and both access the RAM at the same address in a cycle, lane A's operation completes, `b_ready` is low in that cycle and lane B's command has no effect until a later cycle in which it is accepted.
- R10: Op codes 10 to 15 are no-operations: the pointer is unchanged and no strobe rises.
- R11: Every result strobe is high for exactly the one cycle after the command that produced it; read and jump strobes are never high together on a lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| a_valid | input | 1 | Lane A command valid |
| a_op | input | 4 | Lane A operation code |
| a_operand | input | 32 | Lane A data or immediate operand |
| a_c_in | input | 1 | Lane A carry flag to save on call |
| a_z_in | input | 1 | Lane A zero flag to save on call |
| a_wc | input | 1 | Lane A carry restore enable on return |
| a_wz | input | 1 | Lane A zero restore enable on return |
| b_valid | input | 1 | Lane B command valid |
| b_op | input | 4 | Lane B operation code |
| b_operand | input | 32 | Lane B data or immediate operand |
| b_c_in | input | 1 | Lane B carry flag to save on call |
| b_z_in | input | 1 | Lane B zero flag to save on call |
| b_wc | input | 1 | Lane B carry restore enable on return |
| b_wz | input | 1 | Lane B zero restore enable on return |
| b_ready | output | 1 | Lane B command accepted this cycle |
| a_rd_valid | output | 1 | Lane A read data strobe |
| a_rd_data | output | 32 | Lane A read data |
| a_jmp_valid | output | 1 | Lane A jump strobe |
| a_jmp_addr | output | 9 | Lane A jump address |
| a_c_valid | output | 1 | Lane A carry restore strobe |
| a_c_out | output | 1 | Lane A restored carry |
| a_z_valid | output | 1 | Lane A zero restore strobe |
| a_z_out | output | 1 | Lane A restored zero |
| b_rd_valid | output | 1 | Lane B read data strobe |
| b_rd_data | output | 32 | Lane B read data |
| b_jmp_valid | output | 1 | Lane B jump strobe |
| b_jmp_addr | output | 9 | Lane B jump address |
| b_c_valid | output | 1 | Lane B carry restore strobe |
| b_c_out | output | 1 | Lane B restored carry |
| b_z_valid | output | 1 | Lane B zero restore strobe |
| b_z_out | output | 1 | Lane B restored zero |

## Verification
The bound checker watches, on every cycle, the pointer step after push-up and push-down, the jump strobe that follows every call, that a carry strobe only ever follows a return with its carry enable, that a stalled lane B leaves its pointer untouched and stalls only when both lanes are busy, and that read and jump strobes never coincide. What only the bench's scenarios can show is the data path through the RAM: the exact frame layout of a call, the word a pop brings back after the two lanes interleave on one address, the 7-bit wrap of add, subtract and push-down from zero, and that unused op codes leave the pointer as it was.

// File: rtl/dsm_pkg.sv
package dsm_pkg;
  localparam int OPW = 4;

  localparam logic [OPW-1:0] OP_PUSH_UP = 4'd0;
  localparam logic [OPW-1:0] OP_PUSH_DN = 4'd1;
  localparam logic [OPW-1:0] OP_POP_DN  = 4'd2;
  localparam logic [OPW-1:0] OP_POP_UP  = 4'd3;
  localparam logic [OPW-1:0] OP_SET     = 4'd4;
  localparam logic [OPW-1:0] OP_GET     = 4'd5;
  localparam logic [OPW-1:0] OP_ADD     = 4'd6;
  localparam logic [OPW-1:0] OP_SUB     = 4'd7;
  localparam logic [OPW-1:0] OP_CALL    = 4'd8;
  localparam logic [OPW-1:0] OP_RET     = 4'd9;

  // decoded view of one command
  typedef struct packed {
    logic req;    // touches the RAM
    logic we;     // writes the RAM
    logic pre;    // address is pointer minus one
    logic rd;     // produces read data
    logic jmp;    // produces a jump
  } dec_t;
endpackage

// File: rtl/dsm_rst_sync.sv
module dsm_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_s
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_s = sync_q[1];
endmodule

// File: rtl/dsm_ram.sv
module dsm_ram #(
  parameter int WIDTH = 32,
  parameter int DEPTH = 128,
  parameter int NP    = 2,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic                      clk,
  input  logic [NP-1:0]             we,
  input  logic [NP-1:0][AW-1:0]     addr,
  input  logic [NP-1:0][WIDTH-1:0]  wdata,
  output logic [NP-1:0][WIDTH-1:0]  rdata
);
  logic [WIDTH-1:0] mem [DEPTH];

  // same-address writes are kept apart by the arbiter
  always_ff @(posedge clk) begin
    for (int p = 0; p < NP; p++) begin
      if (we[p]) mem[addr[p]] <= wdata[p];
    end
  end

  for (genvar p = 0; p < NP; p++) begin : g_rd
    assign rdata[p] = mem[addr[p]];
  end
endmodule

// File: rtl/dsm_arb.sv
module dsm_arb #(
  parameter int AW = 7
) (
  input  logic          a_req,
  input  logic [AW-1:0] a_addr,
  input  logic          b_req,
  input  logic [AW-1:0] b_addr,
  output logic          b_ready
);
  logic clash;

  always_comb begin
    clash   = a_req && b_req && (a_addr == b_addr);
    b_ready = !clash;
  end
endmodule

// File: rtl/dsm_lane.sv
module dsm_lane
  import dsm_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int AW     = 7,
  parameter int JW     = 9,
  parameter int RA_LSB = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmd_valid,
  input  logic             go,
  input  logic [OPW-1:0]   op,
  input  logic [WIDTH-1:0] operand,
  input  logic             c_in,
  input  logic             z_in,
  input  logic             wc,
  input  logic             wz,
  input  logic [WIDTH-1:0] mem_rdata,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [WIDTH-1:0] mem_wdata,
  output logic [AW-1:0]    ptr_q,
  output logic             rd_valid,
  output logic [WIDTH-1:0] rd_data,
  output logic             jmp_valid,
  output logic [JW-1:0]    jmp_addr,
  output logic             c_valid,
  output logic             c_out,
  output logic             z_valid,
  output logic             z_out
);
  localparam int ZB = JW;
  localparam int CB = JW + 1;

  dec_t             dec;
  logic [AW-1:0]    ptr_inc, ptr_dec, ptr_d;
  logic [WIDTH-1:0] frame, rd_src;
  logic [JW-1:0]    jmp_src;
  logic             is_ret;

  // next-state and decode
  always_comb begin
    ptr_inc = ptr_q + AW'(1);
    ptr_dec = ptr_q - AW'(1);
    frame   = '0;
    frame[JW-1:0] = operand[RA_LSB +: JW];
    frame[ZB]     = z_in;
    frame[CB]     = c_in;
    dec     = '0;
    ptr_d   = ptr_q;
    is_ret  = 1'b0;
    case (op)
      OP_PUSH_UP: begin dec.req = 1'b1; dec.we = 1'b1; ptr_d = ptr_inc; end
      OP_PUSH_DN: begin dec.req = 1'b1; dec.we = 1'b1; dec.pre = 1'b1; ptr_d = ptr_dec; end
      OP_POP_DN:  begin dec.req = 1'b1; dec.rd = 1'b1; dec.pre = 1'b1; ptr_d = ptr_dec; end
      OP_POP_UP:  begin dec.req = 1'b1; dec.rd = 1'b1; ptr_d = ptr_inc; end
      OP_SET:     ptr_d = operand[AW-1:0];
      OP_GET:     dec.rd = 1'b1;
      OP_ADD:     ptr_d = ptr_q + operand[AW-1:0];
      OP_SUB:     ptr_d = ptr_q - operand[AW-1:0];
      OP_CALL:    begin dec.req = 1'b1; dec.we = 1'b1; dec.jmp = 1'b1; ptr_d = ptr_inc; end
      OP_RET:     begin dec.req = 1'b1; dec.pre = 1'b1; dec.jmp = 1'b1; is_ret = 1'b1; ptr_d = ptr_dec; end
      default:    ;
    endcase
    mem_req   = cmd_valid && dec.req;
    mem_we    = go && dec.we;
    mem_addr  = dec.pre ? ptr_dec : ptr_q;
    mem_wdata = (op == OP_CALL) ? frame : operand;
    rd_src    = (op == OP_GET) ? WIDTH'(ptr_q) : mem_rdata;
    jmp_src   = is_ret ? mem_rdata[JW-1:0] : operand[JW-1:0];
  end

  // pointer register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  ptr_q <= '0;
    else if (go) ptr_q <= ptr_d;
  end

  // result strobes
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_valid  <= 1'b0;
      jmp_valid <= 1'b0;
      c_valid   <= 1'b0;
      z_valid   <= 1'b0;
    end else begin
      rd_valid  <= go && dec.rd;
      jmp_valid <= go && dec.jmp;
      c_valid   <= go && is_ret && wc;
      z_valid   <= go && is_ret && wz;
    end
  end

  // result data, loaded only when produced
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      jmp_addr <= '0;
      c_out    <= 1'b0;
      z_out    <= 1'b0;
    end else begin
      if (go && dec.rd)  rd_data  <= rd_src;
      if (go && dec.jmp) jmp_addr <= jmp_src;
      if (go && is_ret && wc) c_out <= mem_rdata[CB];
      if (go && is_ret && wz) z_out <= mem_rdata[ZB];
    end
  end
endmodule

// File: rtl/dual_stack_mem.sv
module dual_stack_mem
  import dsm_pkg::*;
#(
  parameter int WIDTH  = 32,
  parameter int DEPTH  = 128,
  parameter int JW     = 9,
  parameter int RA_LSB = 16,
  localparam int AW    = $clog2(DEPTH),
  localparam int NL    = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             a_valid,
  input  logic [3:0]       a_op,
  input  logic [WIDTH-1:0] a_operand,
  input  logic             a_c_in,
  input  logic             a_z_in,
  input  logic             a_wc,
  input  logic             a_wz,
  input  logic             b_valid,
  input  logic [3:0]       b_op,
  input  logic [WIDTH-1:0] b_operand,
  input  logic             b_c_in,
  input  logic             b_z_in,
  input  logic             b_wc,
  input  logic             b_wz,
  output logic             b_ready,
  output logic             a_rd_valid,
  output logic [WIDTH-1:0] a_rd_data,
  output logic             a_jmp_valid,
  output logic [JW-1:0]    a_jmp_addr,
  output logic             a_c_valid,
  output logic             a_c_out,
  output logic             a_z_valid,
  output logic             a_z_out,
  output logic             b_rd_valid,
  output logic [WIDTH-1:0] b_rd_data,
  output logic             b_jmp_valid,
  output logic [JW-1:0]    b_jmp_addr,
  output logic             b_c_valid,
  output logic             b_c_out,
  output logic             b_z_valid,
  output logic             b_z_out
);
  logic rst_s;

  logic [NL-1:0]            l_valid, l_go, l_c_in, l_z_in, l_wc, l_wz;
  logic [NL-1:0][3:0]       l_op;
  logic [NL-1:0][WIDTH-1:0] l_operand, l_rdata, l_wdata, l_rd_data;
  logic [NL-1:0]            l_req, l_we;
  logic [NL-1:0][AW-1:0]    l_addr, l_ptr;
  logic [NL-1:0]            l_rd_valid, l_jmp_valid, l_c_valid, l_c_out, l_z_valid, l_z_out;
  logic [NL-1:0][JW-1:0]    l_jmp_addr;
  logic [AW-1:0]            ptr_a, ptr_b;

  dsm_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_s(rst_s));

  assign l_valid   = {b_valid, a_valid};
  assign l_op      = {b_op, a_op};
  assign l_operand = {b_operand, a_operand};
  assign l_c_in    = {b_c_in, a_c_in};
  assign l_z_in    = {b_z_in, a_z_in};
  assign l_wc      = {b_wc, a_wc};
  assign l_wz      = {b_wz, a_wz};
  assign l_go      = {b_valid && b_ready, a_valid};

  dsm_arb #(.AW(AW)) u_arb (
    .a_req  (l_req[0]),
    .a_addr (l_addr[0]),
    .b_req  (l_req[1]),
    .b_addr (l_addr[1]),
    .b_ready(b_ready)
  );

  dsm_ram #(.WIDTH(WIDTH), .DEPTH(DEPTH), .NP(NL)) u_ram (
    .clk  (clk),
    .we   (l_we),
    .addr (l_addr),
    .wdata(l_wdata),
    .rdata(l_rdata)
  );

  for (genvar l = 0; l < NL; l++) begin : g_lane
    dsm_lane #(.WIDTH(WIDTH), .AW(AW), .JW(JW), .RA_LSB(RA_LSB)) u_lane (
      .clk      (clk),
      .rst_n    (rst_s),
      .cmd_valid(l_valid[l]),
      .go       (l_go[l]),
      .op       (l_op[l]),
      .operand  (l_operand[l]),
      .c_in     (l_c_in[l]),
      .z_in     (l_z_in[l]),
      .wc       (l_wc[l]),
      .wz       (l_wz[l]),
      .mem_rdata(l_rdata[l]),
      .mem_req  (l_req[l]),
      .mem_we   (l_we[l]),
      .mem_addr (l_addr[l]),
      .mem_wdata(l_wdata[l]),
      .ptr_q    (l_ptr[l]),
      .rd_valid (l_rd_valid[l]),
      .rd_data  (l_rd_data[l]),
      .jmp_valid(l_jmp_valid[l]),
      .jmp_addr (l_jmp_addr[l]),
      .c_valid  (l_c_valid[l]),
      .c_out    (l_c_out[l]),
      .z_valid  (l_z_valid[l]),
      .z_out    (l_z_out[l])
    );
  end

  assign ptr_a = l_ptr[0];
  assign ptr_b = l_ptr[1];

  assign a_rd_valid  = l_rd_valid[0];
  assign a_rd_data   = l_rd_data[0];
  assign a_jmp_valid = l_jmp_valid[0];
  assign a_jmp_addr  = l_jmp_addr[0];
  assign a_c_valid   = l_c_valid[0];
  assign a_c_out     = l_c_out[0];
  assign a_z_valid   = l_z_valid[0];
  assign a_z_out     = l_z_out[0];
  assign b_rd_valid  = l_rd_valid[1];
  assign b_rd_data   = l_rd_data[1];
  assign b_jmp_valid = l_jmp_valid[1];
  assign b_jmp_addr  = l_jmp_addr[1];
  assign b_c_valid   = l_c_valid[1];
  assign b_c_out     = l_c_out[1];
  assign b_z_valid   = l_z_valid[1];
  assign b_z_out     = l_z_out[1];
endmodule

// File: rtl/dsm_chk.sv
module dsm_chk #(
  parameter int AW = 7
) (
  input logic          clk,
  input logic          rst_s,
  input logic          a_valid,
  input logic [3:0]    a_op,
  input logic          a_wc,
  input logic          b_valid,
  input logic [3:0]    b_op,
  input logic          b_ready,
  input logic [AW-1:0] ptr_a,
  input logic [AW-1:0] ptr_b,
  input logic          a_rd_valid,
  input logic          a_jmp_valid,
  input logic          a_c_valid,
  input logic          b_rd_valid,
  input logic          b_jmp_valid
);
  // R2
  push_up_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (a_valid && a_op == 4'd0) |=> (ptr_a == AW'($past(ptr_a) + AW'(1))));

  // R3
  push_dn_step_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (b_valid && b_ready && b_op == 4'd1) |=> (ptr_b == AW'($past(ptr_b) - AW'(1))));

  // R6
  call_jump_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (a_valid && a_op == 4'd8) |=> a_jmp_valid);

  // R7
  carry_restore_chk: assert property (@(posedge clk) disable iff (!rst_s)
    a_c_valid |-> $past(a_valid && a_op == 4'd9 && a_wc));

  // R9
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_s)
    (b_valid && !b_ready) |=> $stable(ptr_b));

  // R9
  stall_cause_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !b_ready |-> (a_valid && b_valid));

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !(a_rd_valid && a_jmp_valid) && !(b_rd_valid && b_jmp_valid));
endmodule

bind dual_stack_mem dsm_chk #(.AW(AW)) u_chk (
  .clk        (clk),
  .rst_s      (rst_s),
  .a_valid    (a_valid),
  .a_op       (a_op),
  .a_wc       (a_wc),
  .b_valid    (b_valid),
  .b_op       (b_op),
  .b_ready    (b_ready),
  .ptr_a      (ptr_a),
  .ptr_b      (ptr_b),
  .a_rd_valid (a_rd_valid),
  .a_jmp_valid(a_jmp_valid),
  .a_c_valid  (a_c_valid),
  .b_rd_valid (b_rd_valid),
  .b_jmp_valid(b_jmp_valid)
);

// File: tb/dual_stack_mem_test.sv
`timescale 1ns/1ps
module dual_stack_mem_test;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        a_valid, a_c_in, a_z_in, a_wc, a_wz;
  logic [3:0]  a_op;
  logic [31:0] a_operand;
  logic        b_valid, b_c_in, b_z_in, b_wc, b_wz;
  logic [3:0]  b_op;
  logic [31:0] b_operand;
  logic        b_ready;
  logic        a_rd_valid, a_jmp_valid, a_c_valid, a_c_out, a_z_valid, a_z_out;
  logic [31:0] a_rd_data;
  logic [8:0]  a_jmp_addr;
  logic        b_rd_valid, b_jmp_valid, b_c_valid, b_c_out, b_z_valid, b_z_out;
  logic [31:0] b_rd_data;
  logic [8:0]  b_jmp_addr;

  int checks = 0;
  int fails  = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dual_stack_mem uut (.*);

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic idle();
    a_valid = 0; a_op = 0; a_operand = 0; a_c_in = 0; a_z_in = 0; a_wc = 0; a_wz = 0;
    b_valid = 0; b_op = 0; b_operand = 0; b_c_in = 0; b_z_in = 0; b_wc = 0; b_wz = 0;
  endtask

  // one command on a lane; returns at the negedge where its results show
  task automatic run(input bit lane, input logic [3:0] op, input logic [31:0] opnd,
                     input bit c = 0, input bit z = 0, input bit wc = 0, input bit wz = 0);
    if (!lane) begin
      a_valid = 1; a_op = op; a_operand = opnd; a_c_in = c; a_z_in = z; a_wc = wc; a_wz = wz;
    end else begin
      b_valid = 1; b_op = op; b_operand = opnd; b_c_in = c; b_z_in = z; b_wc = wc; b_wz = wz;
    end
    @(posedge clk); @(negedge clk);
    idle();
  endtask

  function automatic logic [31:0] rdv(input bit lane);
    return lane ? {31'd0, b_rd_valid} : {31'd0, a_rd_valid};
  endfunction
  function automatic logic [31:0] rdd(input bit lane);
    return lane ? b_rd_data : a_rd_data;
  endfunction

  task automatic get_ptr(input bit lane, input logic [6:0] exp, input string tag);
    run(lane, 4'd5, 32'd0);
    chk({tag, " get strobe"}, rdv(lane), 1);
    chk({tag, " get value"}, rdd(lane), {25'd0, exp});
  endtask

  task automatic pop_expect(input bit lane, input logic [3:0] op, input logic [31:0] exp, input string tag);
    run(lane, op, 32'd0);
    chk({tag, " pop strobe"}, rdv(lane), 1);
    chk({tag, " pop data"}, rdd(lane), exp);
  endtask

  task automatic t_reset();
    chk("R1 a_rd_valid", a_rd_valid, 0);
    chk("R1 a_jmp_valid", a_jmp_valid, 0);
    chk("R1 b_jmp_valid", b_jmp_valid, 0);
    chk("R1 c/z strobes", {a_c_valid, a_z_valid, b_c_valid, b_z_valid}, 0);
    chk("R1 b_ready", b_ready, 1);
    get_ptr(0, 7'd0, "R1 A");
    get_ptr(1, 7'd0, "R1 B");
  endtask

  task automatic t_push_up_pop_dn();
    run(0, 4'd0, 32'h1111_0001);
    run(0, 4'd0, 32'h2222_0002);
    get_ptr(0, 7'd2, "R2 after pushes");
    pop_expect(0, 4'd2, 32'h2222_0002, "R2 first");
    pop_expect(0, 4'd2, 32'h1111_0001, "R2 second");
    chk("R11 strobe drops", a_rd_valid, 1);
    @(posedge clk); @(negedge clk);
    chk("R11 strobe one cycle", a_rd_valid, 0);
    get_ptr(0, 7'd0, "R2 back to base");
  endtask

  task automatic t_grow_apart();
    a_valid = 1; a_op = 4'd0; a_operand = 32'hA0A0_0000;
    b_valid = 1; b_op = 4'd1; b_operand = 32'hB0B0_007F;
    #1 chk("R8 no stall at 0 vs 127", b_ready, 1);
    @(posedge clk); @(negedge clk);
    idle();
    run(1, 4'd1, 32'hB0B0_007E);
    get_ptr(1, 7'd126, "R8 B wrapped");
    get_ptr(0, 7'd1, "R8 A");
    pop_expect(1, 4'd3, 32'hB0B0_007E, "R3 pop-up first");
    pop_expect(1, 4'd3, 32'hB0B0_007F, "R3 pop-up second");
    get_ptr(1, 7'd0, "R3 B home");
    pop_expect(0, 4'd2, 32'hA0A0_0000, "R8 A data");
  endtask

  task automatic t_ptr_math();
    run(0, 4'd4, 32'h0000_0178);           // bits [6:0] = 0x78 = 120
    get_ptr(0, 7'd120, "R4 set masks high bits");
    run(0, 4'd6, 32'd10);
    get_ptr(0, 7'd2, "R5 add wraps");
    run(0, 4'd7, 32'd5);
    get_ptr(0, 7'd125, "R5 sub wraps");
  endtask

  task automatic t_call_ret();
    run(0, 4'd4, 32'd10);
    run(0, 4'd8, {7'd0, 9'h1A5, 7'd0, 9'h0F3}, 1, 0);
    chk("R6 jump strobe", a_jmp_valid, 1);
    chk("R6 jump target", a_jmp_addr, 9'h0F3);
    chk("R11 no read on call", a_rd_valid, 0);
    get_ptr(0, 7'd11, "R6 ptr step");
    pop_expect(0, 4'd2, 32'h0000_05A5, "R6 frame layout");
    run(0, 4'd8, {7'd0, 9'h1A5, 7'd0, 9'h0F3}, 1, 0);
    run(0, 4'd9, 32'd0, 0, 0, 1, 1);
    chk("R7 jump strobe", a_jmp_valid, 1);
    chk("R7 jump addr", a_jmp_addr, 9'h1A5);
    chk("R7 c/z strobes", {a_c_valid, a_z_valid}, 2'b11);
    chk("R7 c/z values", {a_c_out, a_z_out}, 2'b10);
    get_ptr(0, 7'd10, "R7 ptr step");
    run(0, 4'd8, {7'd0, 9'h033, 7'd0, 9'h044}, 0, 1);
    run(0, 4'd9, 32'd0, 1, 1, 0, 1);
    chk("R7 carry not restored", a_c_valid, 0);
    chk("R7 zero restored", {a_z_valid, a_z_out}, 2'b11);
    chk("R7 second jump", a_jmp_addr, 9'h033);
  endtask

  task automatic t_conflict();
    run(0, 4'd4, 32'd20);
    run(1, 4'd4, 32'd21);
    a_valid = 1; a_op = 4'd0; a_operand = 32'h0000_0055;
    b_valid = 1; b_op = 4'd1; b_operand = 32'h0000_0066;
    #1 chk("R9 b_ready low on clash", b_ready, 0);
    @(posedge clk); @(negedge clk);
    a_valid = 0;
    #1 chk("R9 b_ready back", b_ready, 1);
    @(posedge clk); @(negedge clk);
    idle();
    get_ptr(1, 7'd20, "R9 B ran once");
    pop_expect(0, 4'd2, 32'h0000_0066, "R9 B wrote after A");
    get_ptr(0, 7'd20, "R9 A ptr");
  endtask

  task automatic t_noop();
    run(0, 4'd4, 32'd33);
    run(0, 4'hC, 32'h0000_007F);
    chk("R10 no strobes", {a_rd_valid, a_jmp_valid, a_c_valid, a_z_valid}, 0);
    run(1, 4'hF, 32'h0000_0011);
    chk("R10 no strobes B", {b_rd_valid, b_jmp_valid}, 0);
    get_ptr(0, 7'd33, "R10 A ptr kept");
    get_ptr(1, 7'd20, "R10 B ptr kept");
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=hung expected=finished");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    idle();
    rst_n = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    t_reset();
    t_push_up_pop_dn();
    t_grow_apart();
    t_ptr_math();
    t_call_ret();
    t_conflict();
    t_noop();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule